// File: doc/BRIEF.md
# 4-bit Accumulator Datapath

This block is the arithmetic core of a small nibble-wide processor. It keeps a 4-bit accumulator, a 4-bit auxiliary register, an 8-bit extension register and a carry flag. Each clock cycle it accepts one encoded operation, together with a 4-bit memory operand and a 4-bit immediate. Every result lands in its register on the rising clock edge. All registers drive the outputs directly.

The operations cover the following:
- addition with carry-in and carry-out;
- addition against a memory operand or an immediate, with the carry left alone;
- nibble AND and OR;
- rotate right through the carry;
- forcing the carry to one or to zero;
- copies between the accumulator, the auxiliary register and the 8-bit pair.

An immediate addition that overflows four bits raises a one-cycle skip output. A sequencer outside this block uses that output to drop the next instruction. Fetch, decode from program memory and data-memory addressing are outside this block.

Top module: `dp_accum`

## Requirements
- R1: A synchronous active-high `rst` clears the accumulator, the auxiliary register, the extension register, the carry and `skip_o`. All of them read 0 in the cycle after a reset edge.
- R2: Opcode 4'h1 (add with carry) writes (A + M + CY) mod 16 into A. It sets CY to 1 when A + M + CY exceeds 15, and clears CY otherwise.
- R3: Opcode 4'h2 (add memory) writes (A + M) mod 16 into A. It leaves CY unchanged and keeps `skip_o` at 0.
- R4: Opcode 4'h3 (add immediate) writes (A + I) mod 16 into A and leaves CY unchanged. When A + I exceeds 15, `skip_o` is 1 in the following cycle only. Otherwise it stays 0.
- R5: Opcode 4'h4 writes A AND M into A, and opcode 4'h5 writes A OR M into A. Neither changes CY.
- R6: Opcode 4'h6 (rotate right) produces the following:
  - the new A is {CY, A[3:1]};
  - the new CY is the old A[0].
- R7: Opcode 4'h7 forces CY to 1, and opcode 4'h8 forces CY to 0. Neither changes A.
- R8: Opcode 4'h9 copies A into B, and opcode 4'hA copies B into A.
- R9: Opcode 4'hB loads E with {B, A}, with B in bits 7..4. Opcode 4'hC loads B from E[7:4] and A from E[3:0].
- R10: Opcode 4'h0 and the unused codes 4'hD to 4'hF change no register, and `skip_o` is 0 after them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Encoded operation for this cycle |
| mem_i | input | 4 | Memory operand |
| imm_i | input | 4 | Immediate operand |
| acc_o | output | 4 | Accumulator A |
| aux_o | output | 4 | Auxiliary register B |
| ext_o | output | 8 | Extension register E |
| carry_o | output | 1 | Carry flag CY |
| skip_o | output | 1 | One-cycle skip pulse after an overflowing immediate add |

## Verification
The hardest situation to reach is an exact combination of accumulator value, carry and operand in front of each arithmetic operation. No port loads the accumulator or the carry directly. The bench gets there with a short preamble before each case:
1. An AND with zero clears A.
2. An immediate add then brings A to the wanted value; it never overflows, so no skip is raised.
3. A set-carry or clear-carry operation fixes CY.

The bench then sweeps all 16×16×2 combinations, so every carry boundary and every skip boundary is crossed. The pair transfers are reached by staging B through the A-to-B copy before the pair operations run.

// File: rtl/dp_accum_pkg.sv
package dp_accum_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 4'h0,
    OP_ADC  = 4'h1,
    OP_ADDM = 4'h2,
    OP_ADDI = 4'h3,
    OP_AND  = 4'h4,
    OP_OR   = 4'h5,
    OP_ROR  = 4'h6,
    OP_SETC = 4'h7,
    OP_CLRC = 4'h8,
    OP_A2B  = 4'h9,
    OP_B2A  = 4'hA,
    OP_P2E  = 4'hB,
    OP_E2P  = 4'hC
  } op_e;

  typedef enum logic [2:0] {
    ASRC_SUM, ASRC_AND, ASRC_OR, ASRC_ROR, ASRC_AUX, ASRC_EXT
  } asrc_e;

  typedef enum logic [1:0] {
    CSRC_SUM, CSRC_ROR, CSRC_ONE, CSRC_ZERO
  } csrc_e;

  typedef struct packed {
    logic  a_we;
    asrc_e a_src;
    logic  b_we;
    logic  b_from_e;
    logic  e_we;
    logic  c_we;
    csrc_e c_src;
    logic  use_imm;
    logic  use_cin;
    logic  skip_en;
  } ctl_t;
endpackage

// File: rtl/dp_accum_decode.sv
module dp_accum_decode
  import dp_accum_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output ctl_t            ctl
);
  op_e op_q;
  assign op_q = op_e'(op);

  always_comb begin
    ctl          = '0;
    ctl.a_src    = ASRC_SUM;
    ctl.c_src    = CSRC_SUM;
    case (op_q)
      OP_ADC: begin
        ctl.a_we    = 1'b1;
        ctl.use_cin = 1'b1;
        ctl.c_we    = 1'b1;
        ctl.c_src   = CSRC_SUM;
      end
      OP_ADDM: ctl.a_we = 1'b1;
      OP_ADDI: begin
        ctl.a_we    = 1'b1;
        ctl.use_imm = 1'b1;
        ctl.skip_en = 1'b1;
      end
      OP_AND: begin
        ctl.a_we  = 1'b1;
        ctl.a_src = ASRC_AND;
      end
      OP_OR: begin
        ctl.a_we  = 1'b1;
        ctl.a_src = ASRC_OR;
      end
      OP_ROR: begin
        ctl.a_we  = 1'b1;
        ctl.a_src = ASRC_ROR;
        ctl.c_we  = 1'b1;
        ctl.c_src = CSRC_ROR;
      end
      OP_SETC: begin
        ctl.c_we  = 1'b1;
        ctl.c_src = CSRC_ONE;
      end
      OP_CLRC: begin
        ctl.c_we  = 1'b1;
        ctl.c_src = CSRC_ZERO;
      end
      OP_A2B: ctl.b_we = 1'b1;
      OP_B2A: begin
        ctl.a_we  = 1'b1;
        ctl.a_src = ASRC_AUX;
      end
      OP_P2E: ctl.e_we = 1'b1;
      OP_E2P: begin
        ctl.a_we     = 1'b1;
        ctl.a_src    = ASRC_EXT;
        ctl.b_we     = 1'b1;
        ctl.b_from_e = 1'b1;
      end
      default: ctl = ctl;
    endcase
  end
endmodule

// File: rtl/dp_accum_adder.sv
module dp_accum_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] cy;
  assign cy[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]  = x[i] ^ y[i] ^ cy[i];
    assign cy[i+1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
  end

  assign cout = cy[W];
endmodule

// File: rtl/dp_accum_logic.sv
module dp_accum_logic #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] m,
  input  logic         cin,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] ror_o,
  output logic         ror_c
);
  assign and_o = a & m;
  assign or_o  = a | m;
  assign ror_o = {cin, a[W-1:1]};
  assign ror_c = a[0];
endmodule

// File: rtl/dp_accum.sv
module dp_accum
  import dp_accum_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [OP_W-1:0]      op_i,
  input  logic [NIB_W-1:0]     mem_i,
  input  logic [NIB_W-1:0]     imm_i,
  output logic [NIB_W-1:0]     acc_o,
  output logic [NIB_W-1:0]     aux_o,
  output logic [2*NIB_W-1:0]   ext_o,
  output logic                 carry_o,
  output logic                 skip_o
);
  localparam int EXT_W = 2 * NIB_W;

  ctl_t             ctl;
  logic [NIB_W-1:0] acc_q, aux_q;
  logic [EXT_W-1:0] ext_q;
  logic             cy_q, skip_q;

  logic [NIB_W-1:0] add_y, sum, and_r, or_r, ror_r;
  logic             cout, ror_c;
  logic [NIB_W-1:0] a_nx, b_nx;
  logic             c_nx;

  dp_accum_decode u_dec (
    .op  (op_i),
    .ctl (ctl)
  );

  assign add_y = ctl.use_imm ? imm_i : mem_i;

  dp_accum_adder #(.W(NIB_W)) u_add (
    .x    (acc_q),
    .y    (add_y),
    .cin  (ctl.use_cin & cy_q),
    .sum  (sum),
    .cout (cout)
  );

  dp_accum_logic #(.W(NIB_W)) u_log (
    .a     (acc_q),
    .m     (mem_i),
    .cin   (cy_q),
    .and_o (and_r),
    .or_o  (or_r),
    .ror_o (ror_r),
    .ror_c (ror_c)
  );

  always_comb begin
    case (ctl.a_src)
      ASRC_AND: a_nx = and_r;
      ASRC_OR:  a_nx = or_r;
      ASRC_ROR: a_nx = ror_r;
      ASRC_AUX: a_nx = aux_q;
      ASRC_EXT: a_nx = ext_q[NIB_W-1:0];
      default:  a_nx = sum;
    endcase
  end

  assign b_nx = ctl.b_from_e ? ext_q[EXT_W-1:NIB_W] : acc_q;

  always_comb begin
    case (ctl.c_src)
      CSRC_ROR:  c_nx = ror_c;
      CSRC_ONE:  c_nx = 1'b1;
      CSRC_ZERO: c_nx = 1'b0;
      default:   c_nx = cout;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      aux_q  <= '0;
      ext_q  <= '0;
      cy_q   <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      if (ctl.a_we) acc_q <= a_nx;
      if (ctl.b_we) aux_q <= b_nx;
      if (ctl.e_we) ext_q <= {aux_q, acc_q};
      if (ctl.c_we) cy_q  <= c_nx;
      skip_q <= ctl.skip_en & cout;
    end
  end

  assign acc_o   = acc_q;
  assign aux_o   = aux_q;
  assign ext_o   = ext_q;
  assign carry_o = cy_q;
  assign skip_o  = skip_q;
endmodule

// File: rtl/dp_accum_chk.sv
module dp_accum_chk #(
  parameter int NIB_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [3:0]         op_i,
  input logic [NIB_W-1:0]   mem_i,
  input logic [NIB_W-1:0]   acc_o,
  input logic [NIB_W-1:0]   aux_o,
  input logic [2*NIB_W-1:0] ext_o,
  input logic               carry_o,
  input logic               skip_o
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (acc_o == '0 && aux_o == '0 && ext_o == '0 && !carry_o && !skip_o));

  // R2
  adc_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'h1) |=> carry_o ==
      (({1'b0, $past(acc_o)} + {1'b0, $past(mem_i)} + {{NIB_W{1'b0}}, $past(carry_o)}) > (2**NIB_W - 1)));

  // R3
  addm_keeps_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'h2) |=> ($stable(carry_o) && !skip_o));

  // R4
  skip_source_chk: assert property (@(posedge clk) disable iff (rst)
    skip_o |-> ($past(op_i) == 4'h3 && $stable(carry_o)));

  // R6
  ror_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'h6) |=> (carry_o == $past(acc_o[0]) && acc_o[NIB_W-1] == $past(carry_o)));

  // R7
  setc_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'h7) |=> (carry_o && $stable(acc_o)));

  // R7
  clrc_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'h8) |=> (!carry_o && $stable(acc_o)));

  // R9
  pair_to_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'hB) |=> (ext_o == {$past(aux_o), $past(acc_o)}));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'h0 || op_i > 4'hC) |=>
      ($stable(acc_o) && $stable(aux_o) && $stable(ext_o) && $stable(carry_o) && !skip_o));
endmodule

bind dp_accum dp_accum_chk #(.NIB_W(NIB_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .op_i    (op_i),
  .mem_i   (mem_i),
  .acc_o   (acc_o),
  .aux_o   (aux_o),
  .ext_o   (ext_o),
  .carry_o (carry_o),
  .skip_o  (skip_o)
);

// File: tb/dp_accum_test.sv
module dp_accum_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_i = 4'h0;
  logic [3:0] mem_i = 4'h0;
  logic [3:0] imm_i = 4'h0;
  logic [3:0] acc_o, aux_o;
  logic [7:0] ext_o;
  logic       carry_o, skip_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dp_accum uut (
    .clk     (clk),
    .rst     (rst),
    .op_i    (op_i),
    .mem_i   (mem_i),
    .imm_i   (imm_i),
    .acc_o   (acc_o),
    .aux_o   (aux_o),
    .ext_o   (ext_o),
    .carry_o (carry_o),
    .skip_o  (skip_o)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
      report();
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(logic [3:0] op, logic [3:0] m, logic [3:0] i);
    op_i  = op;
    mem_i = m;
    imm_i = i;
    @(negedge clk);
    op_i  = 4'h0;
  endtask

  task automatic load_a(logic [3:0] v);
    step(4'h4, 4'h0, 4'h0);
    step(4'h3, 4'h0, v);
  endtask

  task automatic load_c(bit c);
    step(c ? 4'h7 : 4'h8, 4'h0, 4'h0);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 acc", acc_o, 0);
    chk("R1 aux", aux_o, 0);
    chk("R1 ext", ext_o, 0);
    chk("R1 carry", carry_o, 0);
    chk("R1 skip", skip_o, 0);

    for (int a = 0; a < 16; a++) begin
      for (int m = 0; m < 16; m++) begin
        for (int c = 0; c < 2; c++) begin
          int s;
          // R2 add with carry
          load_a(a[3:0]); load_c(c[0]);
          step(4'h1, m[3:0], 4'h0);
          s = a + m + c;
          chk("R2 acc", acc_o, s % 16);
          chk("R2 carry", carry_o, (s > 15) ? 1 : 0);
          // R3 add memory, carry kept
          load_a(a[3:0]); load_c(c[0]);
          step(4'h2, m[3:0], 4'h0);
          chk("R3 acc", acc_o, (a + m) % 16);
          chk("R3 carry", carry_o, c);
          chk("R3 skip", skip_o, 0);
          // R4 add immediate with skip pulse
          load_a(a[3:0]); load_c(c[0]);
          step(4'h3, 4'h0, m[3:0]);
          chk("R4 acc", acc_o, (a + m) % 16);
          chk("R4 carry", carry_o, c);
          chk("R4 skip", skip_o, (a + m > 15) ? 1 : 0);
          step(4'h0, 4'h0, 4'h0);
          chk("R4 skip one cycle", skip_o, 0);
          // R5 and / or
          load_a(a[3:0]); load_c(c[0]);
          step(4'h4, m[3:0], 4'h0);
          chk("R5 and", acc_o, a & m);
          chk("R5 and carry", carry_o, c);
          load_a(a[3:0]);
          step(4'h5, m[3:0], 4'h0);
          chk("R5 or", acc_o, a | m);
          chk("R5 or carry", carry_o, c);
        end
      end
      for (int c = 0; c < 2; c++) begin
        // R6 rotate right
        load_a(a[3:0]); load_c(c[0]);
        step(4'h6, 4'h0, 4'h0);
        chk("R6 acc", acc_o, c * 8 + a / 2);
        chk("R6 carry", carry_o, a % 2);
        // R7 set and clear carry
        load_c(c[0]);
        step(4'h7, 4'h0, 4'h0);
        chk("R7 set", carry_o, 1);
        chk("R7 set acc", acc_o, c * 8 + a / 2);
        step(4'h8, 4'h0, 4'h0);
        chk("R7 clear", carry_o, 0);
      end
    end

    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        // R8 A to B
        load_a(b[3:0]);
        step(4'h9, 4'h0, 4'h0);
        load_a(a[3:0]);
        chk("R8 a2b", aux_o, b);
        // R9 pair to E, then E back to pair
        step(4'hB, 4'h0, 4'h0);
        chk("R9 p2e", ext_o, b * 16 + a);
        load_a(4'h0);
        step(4'h9, 4'h0, 4'h0);
        step(4'hC, 4'h0, 4'h0);
        chk("R9 e2p acc", acc_o, a);
        chk("R9 e2p aux", aux_o, b);
        // R8 B to A
        load_a(4'((a + 3) % 16));
        step(4'hA, 4'h0, 4'h0);
        chk("R8 b2a", acc_o, b);
        chk("R8 b2a aux", aux_o, b);
      end
    end

    // R10 idle and unused codes hold everything
    load_a(4'h9); step(4'h9, 4'h0, 4'h0);
    load_a(4'h6); step(4'hB, 4'h0, 4'h0);
    load_a(4'hF); load_c(1'b1);
    foreach (op_i[k]) begin end
    for (int k = 0; k < 4; k++) begin
      logic [3:0] code;
      code = (k == 0) ? 4'h0 : 4'(12 + k);
      step(code, 4'hF, 4'hF);
      chk("R10 acc", acc_o, 4'hF);
      chk("R10 aux", aux_o, 4'h9);
      chk("R10 ext", ext_o, 8'h96);
      chk("R10 carry", carry_o, 1);
      chk("R10 skip", skip_o, 0);
    end

    // R1 reset after activity
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 acc again", acc_o, 0);
    chk("R1 ext again", ext_o, 0);
    chk("R1 carry again", carry_o, 0);

    done = 1'b1;
    report();
  end
endmodule